// File: doc/BRIEF.md
# Indexed Colour Palette Loader

This block holds the colour lookup table of an 8-bit indexed framebuffer and lets software fill it over a small 32-bit register bus. Software first writes a starting palette index to the index register. It then writes colour components to the data register: the first write sets red, the second green and the third blue. After blue the index moves on by one, so a whole palette loads as one stream of data writes.

Only the most significant byte of each bus word carries the value. Every read of the register window returns zero. A second, independent port serves the pixel pipeline: it takes an 8-bit pixel index and returns the 24-bit colour stored there. Each component write changes the stored entry at once, so the pixel side can see an entry that is only partly updated.

Top module: `palette_loader`

## Requirements
- R1: An accepted write at byte offset 0 loads the palette index from write data bits 31:24 and returns the component sequencer to the red step, even in the middle of a triple.
- R2: Accepted writes at byte offset 4 store write data bits 31:24 into the current entry: red, then green, then blue on successive writes. An entry is held as {red[23:16], green[15:8], blue[7:0]}.
- R3: The data write that stores blue also advances the index by one modulo 256 (255 wraps to 0) and returns the sequencer to red.
- R4: Each component write is visible on the pixel port on its own, without waiting for the rest of the triple. The pixel port returns the entry addressed by pix_idx one clock later, as the entry stood before any write on that same edge.
- R5: bus_rdata is zero at all times, including during read accesses.
- R6: A write whose byte enables are not all ones (bus_be != 4'hF) changes neither the palette, the index nor the sequencer.
- R7: Writes at byte offsets 8 and 12, or at any address with bits 1:0 non-zero, change neither the palette, the index nor the sequencer.
- R8: After reset, entries 0 to 254 read 24'h000000, entry 255 reads 24'hFFFFFF, the index is 0 and the sequencer is at red.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Bus access present this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte address within the 16-byte window |
| bus_be | input | 4 | Byte enables; the access counts only when all are set |
| bus_wdata | input | 32 | Write data; bits 31:24 carry the value |
| bus_rdata | output | 32 | Read data, always zero |
| pix_idx | input | 8 | Pixel lookup index |
| pix_rgb | output | 24 | Colour of the entry at pix_idx, one clock later |

## Verification
The assertions assume that the bus inputs are steady around each rising edge and that reset is held long enough to clear the whole table. They place no limit on the order of index and data writes. The stimulus drives every input on the falling edge. It mixes full-word writes with partial byte enables, misaligned addresses, dead offsets and reads, so every decode path is exercised while inputs stay settled at the sampling edge. The pixel index is steered onto the entry under update, and also away from it, to observe partial triples and the one-clock lookup lag.

// File: rtl/palette_pkg.sv
package palette_pkg;
    typedef enum logic [2:0] {
        STEP_R = 3'b001,
        STEP_G = 3'b010,
        STEP_B = 3'b100
    } step_e;

    localparam int WORD_INDEX = 0;
    localparam int WORD_DATA  = 1;
endpackage

// File: rtl/pal_seq.sv
module pal_seq
    import palette_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int COMP_W = 8,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W/8-1:0] bus_be,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output step_e             wr_step,
    output logic [COMP_W-1:0] wr_comp
);
    localparam int WORD_W = ADDR_W - 2;
    localparam int VAL_LSB = DATA_W - COMP_W;

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        step_e            step;
    } seq_t;

    seq_t seq_d, seq_q;
    logic acc, hit_index, hit_data;
    logic [COMP_W-1:0] val;

    always_comb begin
        acc       = bus_valid && bus_write && (&bus_be) && (bus_addr[1:0] == 2'b00);
        hit_index = acc && (bus_addr[ADDR_W-1:2] == WORD_W'(WORD_INDEX));
        hit_data  = acc && (bus_addr[ADDR_W-1:2] == WORD_W'(WORD_DATA));
        val       = bus_wdata[DATA_W-1:VAL_LSB];
        seq_d     = seq_q;
        if (hit_index) begin
            seq_d.idx  = IDX_W'(val);
            seq_d.step = STEP_R;
        end else if (hit_data) begin
            unique case (seq_q.step)
                STEP_R:  seq_d.step = STEP_G;
                STEP_G:  seq_d.step = STEP_B;
                default: begin
                    seq_d.step = STEP_R;
                    seq_d.idx  = seq_q.idx + 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{idx: '0, step: STEP_R};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign wr_en   = hit_data;
    assign wr_idx  = seq_q.idx;
    assign wr_step = seq_q.step;
    assign wr_comp = val;

    AST_STEP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(seq_q.step)); // R2
    AST_INDEX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_be == '1 && bus_addr == '0)
        |=> (seq_q.step == STEP_R && seq_q.idx == $past(bus_wdata[DATA_W-1 -: IDX_W]))); // R1
    AST_INDEX_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && seq_q.step == STEP_B)
        |=> (seq_q.step == STEP_R && seq_q.idx == IDX_W'($past(seq_q.idx) + 1'b1))); // R3
    AST_PARTIAL_BE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_be != '1)
        |=> ($stable(seq_q.idx) && $stable(seq_q.step))); // R6
    AST_DEAD_OFFSET_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_addr[ADDR_W-1:3] != '0)
        |=> ($stable(seq_q.idx) && $stable(seq_q.step))); // R7
endmodule

// File: rtl/pal_store.sv
module pal_store
    import palette_pkg::*;
#(
    parameter int IDX_W   = 8,
    parameter int COMP_W  = 8,
    parameter bit PIX_REG = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  step_e               wr_step,
    input  logic [COMP_W-1:0]   wr_comp,
    input  logic [IDX_W-1:0]    pix_idx,
    output logic [3*COMP_W-1:0] pix_rgb
);
    localparam int NUM_ENT = 1 << IDX_W;
    localparam int ENT_W   = 3 * COMP_W;

    logic [ENT_W-1:0] ent_d [NUM_ENT];
    logic [ENT_W-1:0] ent_q [NUM_ENT];

    always_comb begin
        for (int i = 0; i < NUM_ENT; i++) ent_d[i] = ent_q[i];
        if (wr_en) begin
            unique case (wr_step)
                STEP_R:  ent_d[wr_idx][ENT_W-1 -: COMP_W]    = wr_comp;
                STEP_G:  ent_d[wr_idx][2*COMP_W-1 -: COMP_W] = wr_comp;
                default: ent_d[wr_idx][COMP_W-1:0]           = wr_comp;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_ENT; i++)
                ent_q[i] <= (i == NUM_ENT - 1) ? {ENT_W{1'b1}} : {ENT_W{1'b0}};
        end else begin
            for (int i = 0; i < NUM_ENT; i++) ent_q[i] <= ent_d[i];
        end
    end

    generate
        if (PIX_REG) begin : g_pix_reg
            logic [ENT_W-1:0] pix_d, pix_q;
            always_comb pix_d = ent_q[pix_idx];
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pix_q <= '0;
                else        pix_q <= pix_d;
            end
            assign pix_rgb = pix_q;
        end else begin : g_pix_comb
            assign pix_rgb = ent_q[pix_idx];
        end
    endgenerate

    AST_RED_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_step == STEP_R)
        |=> (ent_q[$past(wr_idx)][ENT_W-1 -: COMP_W] == $past(wr_comp))); // R2
    AST_BLUE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_step == STEP_B)
        |=> (ent_q[$past(wr_idx)][COMP_W-1:0] == $past(wr_comp))); // R4
endmodule

// File: rtl/palette_loader.sv
module palette_loader
    import palette_pkg::*;
#(
    parameter int IDX_W   = 8,
    parameter int COMP_W  = 8,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 4,
    parameter bit PIX_REG = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_valid,
    input  logic                bus_write,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W/8-1:0] bus_be,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [IDX_W-1:0]    pix_idx,
    output logic [3*COMP_W-1:0] pix_rgb
);
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    step_e             wr_step;
    logic [COMP_W-1:0] wr_comp;

    pal_seq #(
        .IDX_W(IDX_W), .COMP_W(COMP_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_be(bus_be), .bus_wdata(bus_wdata),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_step(wr_step), .wr_comp(wr_comp)
    );

    pal_store #(
        .IDX_W(IDX_W), .COMP_W(COMP_W), .PIX_REG(PIX_REG)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_step(wr_step), .wr_comp(wr_comp),
        .pix_idx(pix_idx), .pix_rgb(pix_rgb)
    );

    // The register window is write-only; every read returns zero (R5).
    assign bus_rdata = '0;
endmodule

// File: tb/palette_loader_bench.sv
`timescale 1ns/1ps
module palette_loader_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  pix_idx = '0;
    logic [23:0] pix_rgb;

    always #2 clk = ~clk;

    palette_loader u_palette_loader (
        .clk(clk), .rst_n(rst_n),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pix_idx(pix_idx), .pix_rgb(pix_rgb)
    );

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    string cur_req = "R8";

    // Behavioural reference
    int          m_r [256];
    int          m_g [256];
    int          m_b [256];
    int          m_idx;
    int          m_step;
    logic [23:0] exp_pix;

    task automatic model_reset();
        for (int i = 0; i < 256; i++) begin
            m_r[i] = (i == 255) ? 255 : 0;
            m_g[i] = m_r[i];
            m_b[i] = m_r[i];
        end
        m_idx = 0;
        m_step = 0;
        exp_pix = 24'h0;
    endtask

    initial model_reset();

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            model_reset();
        end else begin
            exp_pix = {m_r[pix_idx][7:0], m_g[pix_idx][7:0], m_b[pix_idx][7:0]};
            if (bus_valid && bus_write && bus_be == 4'hF) begin
                if (bus_addr == 4'd0) begin
                    m_idx = int'(bus_wdata[31:24]);
                    m_step = 0;
                end else if (bus_addr == 4'd4) begin
                    if (m_step == 0) m_r[m_idx] = int'(bus_wdata[31:24]);
                    else if (m_step == 1) m_g[m_idx] = int'(bus_wdata[31:24]);
                    else m_b[m_idx] = int'(bus_wdata[31:24]);
                    if (m_step == 2) begin
                        m_step = 0;
                        m_idx = (m_idx + 1) % 256;
                    end else begin
                        m_step++;
                    end
                end
            end
        end
    end

    // Compare every cycle, away from the rising edge
    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (pix_rgb !== exp_pix) begin
                failures++;
                $display("FAIL %s pix_rgb actual=%h expected=%h (cycle %0d)",
                         cur_req, pix_rgb, exp_pix, cycles);
            end
            checks++;
            if (bus_rdata !== 32'h0) begin
                failures++;
                $display("FAIL R5 bus_rdata actual=%h expected=00000000", bus_rdata);
            end
        end
    end

    task automatic op(input logic v, input logic w, input logic [3:0] a,
                      input logic [3:0] be, input logic [7:0] val, input logic [7:0] pidx);
        @(negedge clk);
        bus_valid = v;
        bus_write = w;
        bus_addr  = a;
        bus_be    = be;
        bus_wdata = {val, 24'h5A5A5A};
        pix_idx   = pidx;
    endtask

    task automatic idle(input logic [7:0] pidx);
        op(1'b0, 1'b0, 4'd0, 4'h0, 8'h00, pidx);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R8: sweep the whole table after reset
        cur_req = "R8";
        for (int i = 0; i < 256; i++) idle(8'(i));
        idle(8'd255);
        idle(8'd0);
        // R2/R4: one triple, pixel port watching the entry under update
        cur_req = "R4";
        op(1, 1, 4'd0, 4'hF, 8'd10, 8'd10);
        op(1, 1, 4'd4, 4'hF, 8'h12, 8'd10);
        op(1, 1, 4'd4, 4'hF, 8'h34, 8'd10);
        op(1, 1, 4'd4, 4'hF, 8'h56, 8'd10);
        idle(8'd10);
        idle(8'd10);
        // R3: continuing writes fill the next entry
        cur_req = "R3";
        op(1, 1, 4'd4, 4'hF, 8'hA1, 8'd11);
        op(1, 1, 4'd4, 4'hF, 8'hB2, 8'd11);
        op(1, 1, 4'd4, 4'hF, 8'hC3, 8'd11);
        idle(8'd11);
        // R3: wrap from 255 to 0
        op(1, 1, 4'd0, 4'hF, 8'd255, 8'd255);
        op(1, 1, 4'd4, 4'hF, 8'h01, 8'd255);
        op(1, 1, 4'd4, 4'hF, 8'h02, 8'd255);
        op(1, 1, 4'd4, 4'hF, 8'h03, 8'd255);
        op(1, 1, 4'd4, 4'hF, 8'h44, 8'd0);
        op(1, 1, 4'd4, 4'hF, 8'h55, 8'd0);
        op(1, 1, 4'd4, 4'hF, 8'h66, 8'd0);
        idle(8'd0);
        idle(8'd1);
        // R1: index write in mid triple restarts at red
        cur_req = "R1";
        op(1, 1, 4'd0, 4'hF, 8'd20, 8'd20);
        op(1, 1, 4'd4, 4'hF, 8'h77, 8'd20);
        op(1, 1, 4'd0, 4'hF, 8'd30, 8'd20);
        op(1, 1, 4'd4, 4'hF, 8'h88, 8'd30);
        op(1, 1, 4'd4, 4'hF, 8'h99, 8'd30);
        idle(8'd30);
        idle(8'd20);
        // R6: partial byte enables ignored (index write and data write)
        cur_req = "R6";
        op(1, 1, 4'd4, 4'h7, 8'hEE, 8'd30);
        op(1, 1, 4'd0, 4'hE, 8'd40, 8'd30);
        op(1, 1, 4'd4, 4'h8, 8'hEE, 8'd30);
        op(1, 1, 4'd4, 4'hF, 8'hBB, 8'd30);
        idle(8'd30);
        idle(8'd40);
        // R7: dead offsets and misaligned addresses ignored
        cur_req = "R7";
        op(1, 1, 4'd8,  4'hF, 8'hDE, 8'd31);
        op(1, 1, 4'd12, 4'hF, 8'd50, 8'd31);
        op(1, 1, 4'd5,  4'hF, 8'hDE, 8'd31);
        op(1, 1, 4'd1,  4'hF, 8'd60, 8'd31);
        op(1, 1, 4'd4,  4'hF, 8'hC0, 8'd31);
        op(1, 1, 4'd4,  4'hF, 8'hC1, 8'd31);
        op(1, 1, 4'd4,  4'hF, 8'hC2, 8'd31);
        idle(8'd31);
        idle(8'd32);
        // R5: reads return zero and change nothing
        cur_req = "R5";
        op(1, 0, 4'd0, 4'hF, 8'd70, 8'd32);
        op(1, 0, 4'd4, 4'hF, 8'hAA, 8'd32);
        op(1, 0, 4'd8, 4'hF, 8'hAA, 8'd32);
        op(1, 1, 4'd4, 4'hF, 8'h0F, 8'd32);
        idle(8'd32);
        idle(8'd70);
        // R2: final sweep of all entries against the model
        cur_req = "R2";
        for (int i = 0; i < 256; i++) idle(8'(i));
        idle(8'd0);
        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #100000;
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule